// File: doc/BRIEF.md
# Multicart PRG/CHR Bank Mapper

This block is the address-translation core of a cartridge bank mapper for an 8-bit console. The CPU programs it through writes in the upper half of its address space and at one low address; from those registers it derives, with no added latency, the 8 KB program ROM bank behind the CPU address currently presented and the 1 KB character ROM bank behind the pattern-table slot the video side is reading. It also drives the nametable mirroring select.

Two layers of banking are combined. An inner layer holds a bank-select pointer and eight bank registers: two 2 KB character pairs, four 1 KB character banks and two 8 KB program banks. Two pointer bits swap slot order. An outer layer is a 2-bit bank number. It shifts every program bank by multiples of eight and every character bank by 128 when its upper bit is set. A variant strap changes both how the outer bank is written and which fixed program banks fill the last slots.

Top module: `mbm_top`

## Requirements
- R1: After reset the outputs map program slots 0..3 (CPU address bits 14:13) to banks 0, 1, 14, 15 and character slots 0..7 to banks 0..7, with mirroring vertical (mirror_horiz_o = 0).
- R2: A write with cpu_addr_i bit 15 set is decoded from address bits 14, 13 and 0 only; any other address bits are ignored. {14,13,0} = 000 is the pointer, 001 the bank data, 010 the mirroring.
- R3: A bank-data write stores cpu_data_i into bank register n, where n is pointer bits [2:0]. Registers 0..1 are the 2 KB character pairs, 2..5 the 1 KB character banks, and 6..7 the program banks.
- R4: Writes to registers 0 and 1 store the data with bit 0 forced to 0. Character slots 2k and 2k+1 of a pair then read value and value+1.
- R5: A write to exactly 0x6000 sets the outer bank to {data[0],0} when variant_i = 0, and to data[2:1] when variant_i = 1.
- R6: Each program slot reads outer×8 plus a slot value. With pointer bit 6 at 0 the four slots take register 6, register 7, fixed-low and fixed-high. With bit 6 at 1 they take fixed-low, register 7, register 6 and fixed-high.
- R7: The fixed-low and fixed-high values are 14 and 15. When variant_i = 1 and the outer bank is not 2, they are 6 and 7 instead.
- R8: Each character slot adds 128 when outer bank bit 1 is set. Pointer bit 7 = 1 exchanges the slot halves 0..3 and 4..7.
- R9: A write to the mirroring address sets mirror_horiz_o to data bit 0 (1 = horizontal, 0 = vertical).
- R10: Writes with {14,13,0} = 011 or 1xx, writes below 0x8000 other than 0x6000, and cycles with cpu_wr_i low change no output.
- R11: Bank outputs follow cpu_addr_i and ppu_addr_hi_i in the same cycle. A register write is visible right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU write strobe, sampled at the rising edge |
| cpu_addr_i | input | ADDR_W | CPU address for writes and program lookup |
| cpu_data_i | input | DATA_W | CPU write data |
| variant_i | input | 1 | Board variant strap |
| ppu_addr_hi_i | input | 3 | Pattern-table address bits 12:10 (1 KB slot) |
| prg_bank_o | output | DATA_W+1 | 8 KB program bank for cpu_addr_i |
| chr_bank_o | output | DATA_W+1 | 1 KB character bank for the selected slot |
| mirror_horiz_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The properties assume that cpu_wr_i, cpu_addr_i and cpu_data_i are known and settled at each rising edge, so that a write is judged only by the address present in that cycle. The strap variant_i is treated as an ordinary input that may change between writes. The stimulus drives every input on the falling edge with fully defined values. It mixes aliased high addresses, the exact outer-bank address, its near neighbours and idle cycles that carry write data. The strap is toggled only between complete write cycles.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned NUM_CHR   = 6;
  localparam int unsigned NUM_SLOTS = 8;
  localparam int unsigned OUTER_W   = 2;

  // {addr[14], addr[13], addr[0]}
  typedef enum logic [2:0] {
    WS_POINTER = 3'b000,
    WS_BANK    = 3'b001,
    WS_MIRROR  = 3'b010,
    WS_SPARE   = 3'b011,
    WS_HOLD_0  = 3'b100,
    WS_HOLD_1  = 3'b101,
    WS_HOLD_2  = 3'b110,
    WS_HOLD_3  = 3'b111
  } wsel_e;

  function automatic int unsigned bank_reset_val(int unsigned idx);
    if (idx < 2)      return idx * 2;
    else if (idx < 6) return idx + 2;
    else              return idx - 6;
  endfunction
endpackage

// File: rtl/mbm_regs.sv
module mbm_regs
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OUTER_ADDR = 'h6000
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  data_i,
  input  logic                               variant_i,
  output logic [2:0]                         ptr_o,
  output logic                               prg_swap_o,
  output logic                               chr_swap_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    bank_o,
  output logic [OUTER_W-1:0]                 outer_o,
  output logic                               mirror_o
);
  logic  hi_hit;
  logic  outer_hit;
  wsel_e sel;

  assign hi_hit    = wr_i & addr_i[ADDR_W-1];
  assign sel       = wsel_e'({addr_i[ADDR_W-2 -: 2], addr_i[0]});
  assign outer_hit = wr_i & (addr_i == OUTER_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o      <= '0;
      prg_swap_o <= 1'b0;
      chr_swap_o <= 1'b0;
    end else if (hi_hit && sel == WS_POINTER) begin
      ptr_o      <= data_i[2:0];
      prg_swap_o <= data_i[6];
      chr_swap_o <= data_i[7];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_o[g] <= DATA_W'(bank_reset_val(g));
      end else if (hi_hit && sel == WS_BANK && ptr_o == 3'(g)) begin
        if (g < 2) bank_o[g] <= {data_i[DATA_W-1:1], 1'b0};
        else       bank_o[g] <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mirror_o <= 1'b0;
    else if (hi_hit && sel == WS_MIRROR) mirror_o <= data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        outer_o <= '0;
    else if (outer_hit) outer_o <= variant_i ? data_i[2:1] : {data_i[0], 1'b0};
  end
endmodule

// File: rtl/mbm_prg_map.sv
module mbm_prg_map
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BANK_W = DATA_W + 1
) (
  input  logic [1:0]         slot_i,
  input  logic               swap_i,
  input  logic               variant_i,
  input  logic [OUTER_W-1:0] outer_i,
  input  logic [DATA_W-1:0]  r6_i,
  input  logic [DATA_W-1:0]  r7_i,
  output logic [BANK_W-1:0]  bank_o
);
  localparam logic [DATA_W-1:0] FIX_LO_STD = DATA_W'(14);
  localparam logic [DATA_W-1:0] FIX_HI_STD = DATA_W'(15);
  localparam logic [DATA_W-1:0] FIX_LO_ALT = DATA_W'(6);
  localparam logic [DATA_W-1:0] FIX_HI_ALT = DATA_W'(7);
  localparam logic [OUTER_W-1:0] OUTER_KEEP = OUTER_W'(2);

  logic              alt;
  logic [DATA_W-1:0] fix_lo, fix_hi, val;

  assign alt    = variant_i && (outer_i != OUTER_KEEP);
  assign fix_lo = alt ? FIX_LO_ALT : FIX_LO_STD;
  assign fix_hi = alt ? FIX_HI_ALT : FIX_HI_STD;

  always_comb begin
    unique case (slot_i)
      2'd0:    val = swap_i ? fix_lo : r6_i;
      2'd1:    val = r7_i;
      2'd2:    val = swap_i ? r6_i : fix_lo;
      default: val = fix_hi;
    endcase
  end

  assign bank_o = BANK_W'({outer_i, 3'b000}) + BANK_W'(val);
endmodule

// File: rtl/mbm_chr_map.sv
module mbm_chr_map
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BANK_W = DATA_W + 1
) (
  input  logic [NUM_CHR-1:0][DATA_W-1:0] chr_i,
  input  logic [2:0]                     slot_i,
  input  logic                           swap_i,
  input  logic                           outer_hi_i,
  output logic [BANK_W-1:0]              bank_o
);
  localparam logic [BANK_W-1:0] OUTER_STEP = BANK_W'(2 * 64);

  logic [NUM_SLOTS-1:0][BANK_W-1:0] slot_val;
  logic [2:0]                       eff;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gen_slot
    if (g < 4) begin : gen_pair
      assign slot_val[g] = BANK_W'(chr_i[g/2]) + BANK_W'(g % 2);
    end else begin : gen_single
      assign slot_val[g] = BANK_W'(chr_i[g-2]);
    end
  end

  assign eff    = slot_i ^ {swap_i, 2'b00};
  assign bank_o = slot_val[eff] + (outer_hi_i ? OUTER_STEP : '0);
endmodule

// File: rtl/mbm_top.sv
module mbm_top
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OUTER_ADDR = 'h6000,
  localparam int unsigned BANK_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              variant_i,
  input  logic [2:0]        ppu_addr_hi_i,
  output logic [BANK_W-1:0] prg_bank_o,
  output logic [BANK_W-1:0] chr_bank_o,
  output logic              mirror_horiz_o
);
  logic [2:0]                      ptr_q;
  logic                            prg_swap_q, chr_swap_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [OUTER_W-1:0]              outer_q;
  logic [NUM_CHR-1:0][DATA_W-1:0]  chr_regs;

  mbm_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUTER_ADDR(OUTER_ADDR)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cpu_wr_i),
    .addr_i    (cpu_addr_i),
    .data_i    (cpu_data_i),
    .variant_i (variant_i),
    .ptr_o     (ptr_q),
    .prg_swap_o(prg_swap_q),
    .chr_swap_o(chr_swap_q),
    .bank_o    (bank_q),
    .outer_o   (outer_q),
    .mirror_o  (mirror_horiz_o)
  );

  for (genvar g = 0; g < NUM_CHR; g++) begin : gen_chr_tap
    assign chr_regs[g] = bank_q[g];
  end

  mbm_prg_map #(.DATA_W(DATA_W)) u_prg (
    .slot_i   (cpu_addr_i[ADDR_W-2 -: 2]),
    .swap_i   (prg_swap_q),
    .variant_i(variant_i),
    .outer_i  (outer_q),
    .r6_i     (bank_q[6]),
    .r7_i     (bank_q[7]),
    .bank_o   (prg_bank_o)
  );

  mbm_chr_map #(.DATA_W(DATA_W)) u_chr (
    .chr_i     (chr_regs),
    .slot_i    (ppu_addr_hi_i),
    .swap_i    (chr_swap_q),
    .outer_hi_i(outer_q[1]),
    .bank_o    (chr_bank_o)
  );
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OUTER_ADDR = 'h6000,
  localparam int unsigned BANK_W = DATA_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_wr_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              data0_i,
  input logic              variant_i,
  input logic              slot_top_i,
  input logic              slot_odd_i,
  input logic [BANK_W-1:0] prg_bank_o,
  input logic [BANK_W-1:0] chr_bank_o,
  input logic              mirror_horiz_o,
  input logic              chr_swap_q,
  input logic [1:0]        outer_q
);
  logic mirror_hit, outer_hit;
  assign mirror_hit = cpu_wr_i && cpu_addr_i[ADDR_W-1 -: 3] == 3'b101 && !cpu_addr_i[0];
  assign outer_hit  = cpu_wr_i && cpu_addr_i == OUTER_ADDR;

  a_r9_mirror_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_hit |=> mirror_horiz_o == $past(data0_i));

  a_r10_mirror_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mirror_hit |=> $stable(mirror_horiz_o));

  a_r5_outer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !outer_hit |=> $stable(outer_q));

  a_r5_outer_normal_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outer_hit && !variant_i) |=> !outer_q[0]);

  a_r7_last_slot_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[ADDR_W-1 -: 3] == 3'b111 |-> (prg_bank_o[2:0] == 3'b111 && prg_bank_o >= BANK_W'(7)));

  a_r4_pair_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_top_i == chr_swap_q && !slot_odd_i) |-> !chr_bank_o[0]);

  a_r8_chr_outer_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outer_q[1] |-> chr_bank_o >= BANK_W'(128));
endmodule

bind mbm_top mbm_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUTER_ADDR(OUTER_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_addr_i    (cpu_addr_i),
  .data0_i       (cpu_data_i[0]),
  .variant_i     (variant_i),
  .slot_top_i    (ppu_addr_hi_i[2]),
  .slot_odd_i    (ppu_addr_hi_i[0]),
  .prg_bank_o    (prg_bank_o),
  .chr_bank_o    (chr_bank_o),
  .mirror_horiz_o(mirror_horiz_o),
  .chr_swap_q    (chr_swap_q),
  .outer_q       (outer_q)
);

// File: tb/sim_mbm_top.sv
module sim_mbm_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        variant_i = 1'b0;
  logic [2:0]  ppu_addr_hi_i = '0;
  logic [8:0]  prg_bank_o, chr_bank_o;
  logic        mirror_horiz_o;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [7:0] m_regs [8];
  logic [2:0] m_ptr;
  logic       m_pswap, m_cswap, m_mirror;
  logic [1:0] m_outer;

  always #(CLK_P/2) clk = ~clk;

  mbm_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i),
    .cpu_data_i(cpu_data_i), .variant_i(variant_i), .ppu_addr_hi_i(ppu_addr_hi_i),
    .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o), .mirror_horiz_o(mirror_horiz_o)
  );

  task automatic model_reset();
    m_regs = '{8'd0, 8'd2, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1};
    m_ptr = 0; m_pswap = 0; m_cswap = 0; m_mirror = 0; m_outer = 0;
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a == 16'h6000) begin
      m_outer = variant_i ? d[2:1] : {d[0], 1'b0};
    end else if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: begin m_ptr = d[2:0]; m_pswap = d[6]; m_cswap = d[7]; end
        3'b001: m_regs[m_ptr] = (m_ptr < 2) ? (d & 8'hFE) : d;
        3'b010: m_mirror = d[0];
        default: ;
      endcase
    end
  endtask

  function automatic int exp_prg(logic [1:0] s);
    int lo, hi, v;
    lo = (variant_i && m_outer != 2) ? 6 : 14;
    hi = lo + 1;
    case (s)
      2'd0:    v = m_pswap ? lo : int'(m_regs[6]);
      2'd1:    v = int'(m_regs[7]);
      2'd2:    v = m_pswap ? int'(m_regs[6]) : lo;
      default: v = hi;
    endcase
    return int'(m_outer) * 8 + v;
  endfunction

  function automatic int exp_chr(logic [2:0] k);
    logic [2:0] e;
    int v;
    e = k ^ {m_cswap, 2'b00};
    if (e < 4) v = int'(m_regs[e >> 1]) + int'(e[0]);
    else       v = int'(m_regs[e - 2]);
    return v + (m_outer[1] ? 128 : 0);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d, logic en = 1'b1);
    @(negedge clk);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = en;
    @(negedge clk);
    cpu_wr_i = 1'b0;
    if (en) model_write(a, d);
  endtask

  task automatic see_prg(string req, int s, int exp);
    @(negedge clk);
    cpu_addr_i = {1'b1, 2'(s), 13'($urandom)};
    #1 chk(req, $sformatf("prg slot %0d", s), int'(prg_bank_o), exp);
  endtask

  task automatic see_chr(string req, int k, int exp);
    @(negedge clk);
    ppu_addr_hi_i = 3'(k);
    #1 chk(req, $sformatf("chr slot %0d", k), int'(chr_bank_o), exp);
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 4; s++) see_prg(req, s, exp_prg(2'(s)));
    for (int k = 0; k < 8; k++) see_chr(req, k, exp_chr(3'(k)));
    chk(req, "mirror", int'(mirror_horiz_o), int'(m_mirror));
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    see_prg("R1", 0, 0); see_prg("R1", 1, 1); see_prg("R1", 2, 14); see_prg("R1", 3, 15);
    for (int k = 0; k < 8; k++) see_chr("R1", k, k);
    chk("R1", "mirror", int'(mirror_horiz_o), 0);

    // R3 bank data into register 6, visible right after the edge (R11)
    do_write(16'h8000, 8'h06);
    do_write(16'h8001, 8'h21);
    see_prg("R3", 0, 33);
    see_prg("R11", 0, 33);
    check_all("R3");

    // R4 pair register even
    do_write(16'h8000, 8'h00);
    do_write(16'h8001, 8'h13);
    see_chr("R4", 0, 18); see_chr("R4", 1, 19);
    do_write(16'h8000, 8'h01);
    do_write(16'h8001, 8'h2B);
    see_chr("R4", 2, 42); see_chr("R4", 3, 43);

    // R2 aliased addresses
    do_write(16'h9FFE, 8'h07);
    do_write(16'h9FFF, 8'h33);
    see_prg("R2", 1, 51);
    check_all("R2");

    // R6 program swap
    do_write(16'h8000, 8'h40);
    see_prg("R6", 0, 14); see_prg("R6", 2, 33); see_prg("R6", 3, 15);
    check_all("R6");

    // R8 character swap and outer base; R5 normal decode
    do_write(16'h8000, 8'h80);
    see_chr("R8", 4, 18); see_chr("R8", 0, 4);
    do_write(16'h6000, 8'hFF);
    see_chr("R5", 4, 146);
    see_prg("R5", 3, 31);
    check_all("R8");

    // R7 alternate variant
    variant_i = 1'b1;
    do_write(16'h6000, 8'h02);
    see_prg("R7", 3, 15); see_prg("R7", 0, 8 + 33);
    do_write(16'h8000, 8'h40);
    see_prg("R7", 0, 14);
    do_write(16'h6000, 8'h04);
    see_prg("R7", 3, 31); see_prg("R7", 0, 30);
    do_write(16'h6000, 8'h06);
    see_prg("R7", 3, 31); see_prg("R7", 2, 24 + 33);
    check_all("R7");
    variant_i = 1'b0;

    // R9 mirroring
    do_write(16'hA000, 8'h01);
    chk("R9", "mirror", int'(mirror_horiz_o), 1);
    do_write(16'hBFFE, 8'h00);
    chk("R9", "mirror", int'(mirror_horiz_o), 0);
    do_write(16'hA000, 8'h03);

    // R10 ignored writes
    do_write(16'hA001, 8'h00);
    do_write(16'hC000, 8'hFF);
    do_write(16'hE001, 8'h55);
    do_write(16'h6001, 8'h01);
    do_write(16'h7000, 8'h02);
    do_write(16'h8000, 8'hC7, 1'b0);
    do_write(16'h6000, 8'h00, 1'b0);
    check_all("R10");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] a;
      int r;
      r = int'($urandom % 7);
      case (r)
        0: a = {1'b1, 15'($urandom)};
        1: a = 16'h6000;
        2: a = {3'b100, 12'($urandom), 1'b0};
        3: a = {3'b100, 12'($urandom), 1'b1};
        4: a = {3'b101, 12'($urandom), 1'b0};
        5: a = 16'($urandom);
        default: a = 16'h6000 ^ (16'h1 << ($urandom % 16));
      endcase
      if ($urandom % 16 == 0) variant_i = ~variant_i;
      do_write(a, 8'($urandom), ($urandom % 8) != 0);
      check_all("R11");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule